// File: doc/BRIEF.md
# Background Factorial Engine

This block is a small register-mapped arithmetic engine. Software writes an operand N to the value register, and the engine then computes N! in the background. It performs one 32x32 multiply per clock, counting down from N toward 1 and keeping only the low 32 bits. The same register then holds the result. While the loop runs, a busy flag in the status register is set. Software either polls that flag or enables a completion request, which the block sends as a single-cycle pulse to a separate interrupt aggregator as its source bit 0.

Access is through a plain strobe-based register port with an address, a size code and 32-bit write data. Read data is registered and appears in the cycle after the read strobe. The asynchronous active-low reset is synchronised inside the block, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `fact_engine`

## Requirements
- R1: After reset, a 32-bit read of offset 0x08 returns 0, a 32-bit read of offset 0x20 returns 0, `irq_req` is low and `acc_rdata` is 0; read data appears on `acc_rdata` in the cycle after a read strobe and holds until the next read.
- R2: A 32-bit write (size code 2'b10) of value N to offset 0x08 while idle starts a computation. Status bit 0 (busy) reads 1 from the next cycle on, for exactly N+1 consecutive cycles, and then reads 0.
- R3: A write to offset 0x08 while busy is set has no effect: the running computation completes unchanged, with its original result and timing.
- R4: Once busy clears, a 32-bit read of offset 0x08 returns N! modulo 2^32. An operand of 0 or 1 gives 1.
- R5: Status bit 7 is an interrupt enable that software can read and write. A write to offset 0x20 changes only this bit, taking it from write data bit 7. Status reads return busy in bit 0, the enable in bit 7, and 0 in all other bits.
- R6: When a computation completes with the enable set, `irq_req` pulses high for exactly one cycle, in the cycle after the busy flag clears. When the enable is clear, no pulse occurs.
- R7: An access whose size code is not 2'b10 is ignored. Such a write changes no state, and such a read returns 0xFFFFFFFF.
- R8: A 32-bit read of any offset other than 0x08 or 0x20 returns 0xFFFFFFFF, and a write to such an offset changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_wr | input | 1 | Write strobe |
| acc_rd | input | 1 | Read strobe |
| acc_addr | input | ADDR_W (8) | Byte offset of the access |
| acc_size | input | 2 | Access size code; 2'b10 means 32 bits |
| acc_wdata | input | DATA_W (32) | Write data |
| acc_rdata | output | DATA_W (32) | Registered read data |
| irq_req | output | 1 | One-cycle completion request for aggregator source bit 0 |

## Verification
The bench builds the block with its default parameters: `DATA_W` = 32 and `ADDR_W` = 8. Operands are kept below 21 so that each run is short. Operands of 13 and 20 push the product past 2^32, which brings modulo truncation within reach. Operands of 0 and 1 cover the loop's exit at its first step. Polling status on every cycle measures the exact N+1 busy window, and with it the cycle in which the completion pulse appears.

// File: rtl/fact_pkg.sv
package fact_pkg;
  localparam logic [7:0] OFF_VALUE  = 8'h08;
  localparam logic [7:0] OFF_STATUS = 8'h20;
  localparam logic [1:0] SZ_WORD    = 2'b10;
  localparam int         STAT_BUSY  = 0;
  localparam int         STAT_IE    = 7;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } fact_state_e;
endpackage

// File: rtl/fact_rst_sync.sv
module fact_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/fact_regif.sv
module fact_regif
  import fact_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_wr,
  input  logic              acc_rd,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              busy,
  input  logic [DATA_W-1:0] value,
  output logic              start,
  output logic [DATA_W-1:0] operand,
  output logic              ie,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] A_VALUE  = ADDR_W'(OFF_VALUE);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);

  logic              word_ok;
  logic              hit_value;
  logic              hit_status;
  logic              ie_en;
  logic              ie_d;
  logic              ie_q;
  logic              rd_en;
  logic [DATA_W-1:0] status_word;
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;

  assign word_ok    = (acc_size == SZ_WORD);
  assign hit_value  = (acc_addr == A_VALUE);
  assign hit_status = (acc_addr == A_STATUS);

  // start request: only a 32-bit write to the value register while idle
  assign start   = acc_wr & word_ok & hit_value & ~busy;
  assign operand = acc_wdata;

  // interrupt enable next state
  assign ie_en = acc_wr & word_ok & hit_status;
  assign ie_d  = acc_wdata[STAT_IE];

  always_comb begin
    status_word            = '0;
    status_word[STAT_BUSY] = busy;
    status_word[STAT_IE]   = ie_q;
  end

  // read data next state
  assign rd_en = acc_rd;
  always_comb begin
    rdata_d = '1;
    if (word_ok) begin
      if (hit_value)       rdata_d = value;
      else if (hit_status) rdata_d = status_word;
      else                 rdata_d = '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q <= 1'b0;
    end else if (ie_en) begin
      ie_q <= ie_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign ie    = ie_q;
  assign rdata = rdata_q;
endmodule

// File: rtl/fact_core.sv
module fact_core
  import fact_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] operand,
  output logic              busy,
  output logic [DATA_W-1:0] value,
  output logic              done
);
  localparam int PROD_W = 2 * DATA_W;

  fact_state_e       state_q, state_d;
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic [DATA_W-1:0] acc_q, acc_d;
  logic              done_q, done_d;
  logic              state_en;
  logic              cnt_en;
  logic              acc_en;
  logic              last;
  logic [PROD_W-1:0] prod;

  assign last = (cnt_q == '0);
  assign prod = {{DATA_W{1'b0}}, acc_q} * {{DATA_W{1'b0}}, cnt_q};

  // next-state logic
  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    acc_d    = acc_q;
    done_d   = 1'b0;
    state_en = 1'b0;
    cnt_en   = 1'b0;
    acc_en   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d  = ST_RUN;
          state_en = 1'b1;
          cnt_d    = operand;
          cnt_en   = 1'b1;
          acc_d    = DATA_W'(1);
          acc_en   = 1'b1;
        end
      end
      ST_RUN: begin
        if (last) begin
          state_d  = ST_IDLE;
          state_en = 1'b1;
          done_d   = 1'b1;
        end else begin
          acc_d  = prod[DATA_W-1:0];
          acc_en = 1'b1;
          cnt_d  = cnt_q - DATA_W'(1);
          cnt_en = 1'b1;
        end
      end
      default: begin
        state_d  = ST_IDLE;
        state_en = 1'b1;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= ST_IDLE;
    else if (state_en) state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign busy  = (state_q == ST_RUN);
  assign value = acc_q;
  assign done  = done_q;
endmodule

// File: rtl/fact_engine.sv
module fact_engine
  import fact_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_wr,
  input  logic              acc_rd,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              irq_req
);
  logic              rst_sn;
  logic              start;
  logic [DATA_W-1:0] operand;
  logic              busy;
  logic [DATA_W-1:0] value;
  logic              done;
  logic              ie;

  fact_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  fact_regif #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regif (
    .clk       (clk),
    .rst_n     (rst_sn),
    .acc_wr    (acc_wr),
    .acc_rd    (acc_rd),
    .acc_addr  (acc_addr),
    .acc_size  (acc_size),
    .acc_wdata (acc_wdata),
    .busy      (busy),
    .value     (value),
    .start     (start),
    .operand   (operand),
    .ie        (ie),
    .rdata     (acc_rdata)
  );

  fact_core #(
    .DATA_W (DATA_W)
  ) u_core (
    .clk     (clk),
    .rst_n   (rst_sn),
    .start   (start),
    .operand (operand),
    .busy    (busy),
    .value   (value),
    .done    (done)
  );

  assign irq_req = done & ie;
endmodule

// File: rtl/fact_engine_chk.sv
module fact_engine_chk
  import fact_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              ie,
  input logic              irq_req,
  input logic              acc_rd,
  input logic [1:0]        acc_size,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [DATA_W-1:0] acc_rdata
);
  a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  a_r3_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);

  a_r2_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ie);

  a_r6_irq_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req);

  a_r6_irq_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $fell(busy));

  a_r7_bad_size_read: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && acc_size != SZ_WORD) |=> (acc_rdata == '1));

  a_r5_status_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && acc_size == SZ_WORD && acc_addr == ADDR_W'(OFF_STATUS))
      |=> (acc_rdata[6:1] == '0 && acc_rdata[DATA_W-1:8] == '0));
endmodule

bind fact_engine fact_engine_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sn),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .ie        (ie),
  .irq_req   (irq_req),
  .acc_rd    (acc_rd),
  .acc_size  (acc_size),
  .acc_addr  (acc_addr),
  .acc_rdata (acc_rdata)
);

// File: tb/sim_fact_engine.sv
`timescale 1ns/1ps
module sim_fact_engine;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam logic [7:0] A_VAL  = 8'h08;
  localparam logic [7:0] A_STAT = 8'h20;
  localparam logic [1:0] SZW    = 2'b10;

  logic              clk;
  logic              rst_n;
  logic              acc_wr;
  logic              acc_rd;
  logic [ADDR_W-1:0] acc_addr;
  logic [1:0]        acc_size;
  logic [DATA_W-1:0] acc_wdata;
  logic [DATA_W-1:0] acc_rdata;
  logic              irq_req;

  int n_checks;
  int n_fail;
  int irq_count;
  bit finished;

  fact_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_wr    (acc_wr),
    .acc_rd    (acc_rd),
    .acc_addr  (acc_addr),
    .acc_size  (acc_size),
    .acc_wdata (acc_wdata),
    .acc_rdata (acc_rdata),
    .irq_req   (irq_req)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) if (irq_req) irq_count++;

  function automatic logic [31:0] ref_fact(input int unsigned n);
    logic [31:0] r = 32'd1;
    for (int unsigned i = n; i > 0; i--) r = r * i;
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic do_write(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz);
    acc_wr = 1'b1; acc_addr = a; acc_wdata = d; acc_size = sz;
    @(negedge clk);
    acc_wr = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, input logic [1:0] sz, output logic [31:0] d);
    acc_rd = 1'b1; acc_addr = a; acc_size = sz;
    @(negedge clk);
    acc_rd = 1'b0;
    d = acc_rdata;
  endtask

  // Polls status every cycle after a start; returns the busy-cycle count.
  task automatic poll_busy(output int cycles);
    logic [31:0] s;
    cycles = 0;
    for (int k = 0; k < 300; k++) begin
      do_read(A_STAT, SZW, s);
      if (s[0]) cycles++;
      else break;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 rdata after reset", acc_rdata, 32'h0);
    check("R1 irq after reset", {31'b0, irq_req}, 32'h0);
    do_read(A_VAL, SZW, d);  check("R1 value reset", d, 32'h0);
    do_read(A_STAT, SZW, d); check("R1 status reset", d, 32'h0);
  endtask

  task automatic t_fact(input int unsigned n, input bit en);
    logic [31:0] d;
    int cyc;
    int irq0;
    do_write(A_STAT, en ? 32'h80 : 32'h0, SZW);
    irq0 = irq_count;
    do_write(A_VAL, n, SZW);
    poll_busy(cyc);
    check($sformatf("R2 busy cycles n=%0d", n), cyc, n + 1);
    do_read(A_VAL, SZW, d);
    check($sformatf("R4 result n=%0d", n), d, ref_fact(n));
    check($sformatf("R6 irq pulses n=%0d en=%0d", n, en), irq_count - irq0, en ? 1 : 0);
  endtask

  task automatic t_write_while_busy;
    logic [31:0] d;
    int cyc;
    do_write(A_VAL, 32'd6, SZW);
    do_write(A_VAL, 32'd3, SZW);
    do_write(A_VAL, 32'd9, SZW);
    poll_busy(cyc);
    check("R3 busy timing unchanged", cyc + 2, 7);
    do_read(A_VAL, SZW, d);
    check("R3 result unchanged", d, 32'd720);
  endtask

  task automatic t_status_bits;
    logic [31:0] d;
    do_write(A_STAT, 32'hFFFF_FFFF, SZW);
    do_read(A_STAT, SZW, d);
    check("R5 status all-ones write", d, 32'h80);
    do_write(A_STAT, 32'hFFFF_FF7F, SZW);
    do_read(A_STAT, SZW, d);
    check("R5 status clear enable", d, 32'h0);
    do_write(A_VAL, 32'd4, SZW);
    do_write(A_STAT, 32'h80, SZW);
    do_read(A_STAT, SZW, d);
    check("R5 status busy and enable", d, 32'h81);
    begin int c; poll_busy(c); end
    do_write(A_STAT, 32'h0, SZW);
  endtask

  task automatic t_bad_size;
    logic [31:0] d;
    do_write(A_VAL, 32'd5, SZW);
    begin int c; poll_busy(c); end
    do_write(A_VAL, 32'd3, 2'b00);
    do_write(A_VAL, 32'd3, 2'b11);
    do_write(A_STAT, 32'h80, 2'b01);
    do_read(A_STAT, SZW, d);
    check("R7 narrow writes no start/enable", d, 32'h0);
    do_read(A_VAL, SZW, d);
    check("R7 value kept", d, 32'd120);
    do_read(A_VAL, 2'b01, d);
    check("R7 narrow read all ones", d, 32'hFFFF_FFFF);
    do_read(A_STAT, 2'b11, d);
    check("R7 wide read all ones", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    do_read(8'h04, SZW, d);
    check("R8 unmapped read 0x04", d, 32'hFFFF_FFFF);
    do_read(8'h24, SZW, d);
    check("R8 unmapped read 0x24", d, 32'hFFFF_FFFF);
    do_write(8'h0C, 32'd7, SZW);
    do_write(8'h60, 32'hFFFF_FFFF, SZW);
    do_read(A_STAT, SZW, d);
    check("R8 unmapped write status", d, 32'h0);
    do_read(A_VAL, SZW, d);
    check("R8 unmapped write value", d, 32'd120);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_checks = 0; n_fail = 0; irq_count = 0; finished = 1'b0;
    rst_n = 1'b0; acc_wr = 1'b0; acc_rd = 1'b0;
    acc_addr = '0; acc_size = SZW; acc_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fact(0, 1'b0);
    t_fact(1, 1'b1);
    t_fact(5, 1'b0);
    t_fact(12, 1'b1);
    t_fact(13, 1'b1);
    t_fact(20, 1'b0);
    t_write_while_busy();
    t_status_bits();
    t_bad_size();
    t_unmapped();
    finish_run();
  end
endmodule